// File: doc/BRIEF.md
# Slotted Random Access Controller with One-Slot Memory

This block decides, once per time slot, whether a single node on a shared channel transmits in the coming slot. The decision looks back exactly one slot: the pair formed by what the node did in the slot just ended (transmitted or waited) and what the channel reported about that slot (idle, busy, success or failure). That pair selects one of eight programmable 16-bit thresholds. A free-running pseudo-random sequence supplies a sample each slot, and the node transmits when it has something pending and the sample falls below the selected threshold.

A high threshold for the pair "transmitted, success" makes the node keep the channel after a win. Successes then come in runs, which raises channel use. The mean run length, and with it how fairly the channel is shared among nodes, is set by that one threshold. A busy report from the channel always makes the node wait in the next slot, so it does not intrude on a primary user. The block reports the length of the current success run as a saturating counter. Thresholds are written through a small write port, and only while the node is disabled.

The control is a three-state machine. OFF is the disabled state: nothing is sent and thresholds may be written. WAIT and SEND are the enabled states, and the current state is the node's action for the present slot. The named transitions are: power-up (OFF on reset); arm (OFF to WAIT when enable is high); draw-send (WAIT or SEND to SEND on a strobe that wins the draw); draw-wait (WAIT or SEND to WAIT on a strobe that loses it); hold (WAIT or SEND unchanged when there is no strobe); and disarm (WAIT or SEND to OFF when enable is low).

Top module: `slot_access_ctrl`

## Requirements
- R1: After reset, tx_o is 0, streak_o is 0, all eight thresholds are 0, and the node's previous action counts as "waited".
- R2: A write with cfg_we high while enable is low stores cfg_wdata into threshold entry cfg_addr. While enable is high, a write has no effect. The entry index is {action, outcome}: action 1 means the node transmitted. Outcome codes are idle=0, busy=1, success=2, failure=3.
- R3: On a clock edge where the node is enabled (WAIT or SEND) and slot_tick is high, the new action is pending AND (sample < threshold[{tx_o, fb_i}]). tx_o shows the new action from that edge on, so it can be seen one cycle after the strobe is applied.
- R4: The sample is a 16-bit Galois shift register, reset to 16'hACE1. It advances only on a strobe that is processed per R3. On each advance, the next value is (s >> 1) XOR 16'hB400 when bit 0 of s is 1, and s >> 1 otherwise. The sample used by a strobe is the value before that strobe's advance.
- R5: On a processed strobe with fb_i = busy (1), the new action is wait, whatever the threshold holds.
- R6: On a processed strobe, streak_o increments when tx_o is 1 and fb_i = success (2), and it saturates at 15. On any other processed strobe it clears to 0.
- R7: With enable low, the node goes to OFF at the next edge. tx_o and streak_o are then 0, strobes are ignored, and the sample does not advance.
- R8: With the node enabled and slot_tick low, tx_o and streak_o hold their values.
- R9: A node in OFF needs one edge with enable high to reach WAIT, with tx_o 0. It processes strobes only from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Node enable. While low, the thresholds can be written |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | 3 | Threshold index {action, outcome} |
| cfg_wdata | input | 16 | Threshold value |
| slot_tick | input | 1 | Slot boundary strobe, one cycle wide |
| pending | input | 1 | Node has data to send |
| fb_i | input | 2 | Channel outcome of the slot just ended |
| tx_o | output | 1 | Transmit in the current slot |
| streak_o | output | 4 | Current run of consecutive successes |

## Verification
Every result is due exactly one edge after its cause. A strobe applied before edge N gives the new tx_o and streak_o after edge N. A change of enable shows in the state after the edge that samples it. A threshold write takes effect at the edge that samples cfg_we, so the next processed strobe uses the new value. The bench drives all inputs on falling edges. It keeps each strobe high for exactly one rising edge and compares the outputs on the following falling edge, half a cycle after they were due. Its own reference keeps the sample register, the threshold table, the action and the run count, and steps them once for each strobe it applies.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int OUT_W   = 2;
    localparam int IDX_W   = OUT_W + 1;
    localparam int ENTRIES = 1 << IDX_W;

    typedef enum logic [OUT_W-1:0] {
        FB_IDLE    = 2'd0,
        FB_BUSY    = 2'd1,
        FB_SUCCESS = 2'd2,
        FB_FAILURE = 2'd3
    } outcome_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } node_state_t;

endpackage

// File: rtl/sac_lfsr.sv
module sac_lfsr #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     TAPS = 16'hB400,
    parameter logic [W-1:0]     SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] sample_o
);

    logic [W-1:0] s_q;
    logic [W-1:0] s_next;

    always_comb begin
        if (s_q[0]) s_next = (s_q >> 1) ^ TAPS;
        else        s_next = s_q >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     s_q <= SEED;
        else if (adv_i) s_q <= s_next;
    end

    assign sample_o = s_q;

endmodule

// File: rtl/sac_prob_table.sv
module sac_prob_table
    import sac_pkg::*;
#(
    parameter int PROB_W     = 16,
    parameter bit BUSY_GUARD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [PROB_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [PROB_W-1:0] thr_o
);

    logic [PROB_W-1:0] tab_q [ENTRIES];
    logic [PROB_W-1:0] raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
        end else if (we_i && !lock_i) begin
            tab_q[waddr_i] <= wdata_i;
        end
    end

    assign raw = tab_q[ridx_i];

    generate
        if (BUSY_GUARD) begin : g_guard
            always_comb begin
                if (ridx_i[OUT_W-1:0] == FB_BUSY) thr_o = '0;
                else                              thr_o = raw;
            end
        end else begin : g_plain
            assign thr_o = raw;
        end
    endgenerate

endmodule

// File: rtl/sac_streak.sv
module sac_streak #(
    parameter int STREAK_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                step_i,
    input  logic                hit_i,
    output logic [STREAK_W-1:0] count_o
);

    localparam logic [STREAK_W-1:0] MAXV = {STREAK_W{1'b1}};

    logic [STREAK_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_i)   cnt_q <= '0;
        else if (step_i) begin
            if (!hit_i)             cnt_q <= '0;
            else if (cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/slot_access_ctrl.sv
module slot_access_ctrl
    import sac_pkg::*;
#(
    parameter int                PROB_W     = 16,
    parameter int                STREAK_W   = 4,
    parameter logic [PROB_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [PROB_W-1:0] LFSR_SEED  = 16'hACE1,
    parameter bit                BUSY_GUARD = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_addr,
    input  logic [PROB_W-1:0]   cfg_wdata,
    input  logic                slot_tick,
    input  logic                pending,
    input  logic [OUT_W-1:0]    fb_i,
    output logic                tx_o,
    output logic [STREAK_W-1:0] streak_o
);

    node_state_t       state_q, state_d;
    logic              active;
    logic              adv;
    logic              draw;
    logic              won;
    logic [IDX_W-1:0]  pair_idx;
    logic [PROB_W-1:0] sample;
    logic [PROB_W-1:0] thr;

    assign active   = (state_q != ST_OFF);
    assign adv      = active && enable && slot_tick;
    assign pair_idx = {state_q == ST_SEND, fb_i};
    assign draw     = pending && (sample < thr);

    sac_lfsr #(
        .W    (PROB_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .sample_o (sample)
    );

    sac_prob_table #(
        .PROB_W     (PROB_W),
        .BUSY_GUARD (BUSY_GUARD)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (enable),
        .we_i    (cfg_we),
        .waddr_i (cfg_addr),
        .wdata_i (cfg_wdata),
        .ridx_i  (pair_idx),
        .thr_o   (thr)
    );

    assign won = (state_q == ST_SEND) && (fb_i == FB_SUCCESS);

    sac_streak #(
        .STREAK_W (STREAK_W)
    ) u_streak (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!enable),
        .step_i  (adv),
        .hit_i   (won),
        .count_o (streak_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_WAIT;           // arm
            end
            ST_WAIT, ST_SEND: begin
                if (!enable)        state_d = ST_OFF;    // disarm
                else if (slot_tick) state_d = draw ? ST_SEND : ST_WAIT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SEND: tx_o = 1'b1;
            default: tx_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/slot_access_ctrl_checker.sv
module slot_access_ctrl_checker #(
    parameter int STREAK_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                slot_tick,
    input logic                pending,
    input logic [1:0]          fb_i,
    input logic                tx_o,
    input logic [STREAK_W-1:0] streak_o
);

    localparam logic [STREAK_W-1:0] SMAX = {STREAK_W{1'b1}};

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_o && streak_o == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !slot_tick) |=> ($stable(tx_o) && $stable(streak_o)));

    assert_busy_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slot_tick && fb_i == 2'd1) |=> !tx_o);

    assert_no_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slot_tick && !pending) |=> !tx_o);

    assert_streak_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slot_tick && tx_o && fb_i == 2'd2 && streak_o != SMAX)
        |=> (streak_o == $past(streak_o) + 1'b1));

    assert_streak_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slot_tick && !(tx_o && fb_i == 2'd2)) |=> (streak_o == '0));

endmodule

bind slot_access_ctrl slot_access_ctrl_checker #(.STREAK_W(STREAK_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .slot_tick (slot_tick),
    .pending   (pending),
    .fb_i      (fb_i),
    .tx_o      (tx_o),
    .streak_o  (streak_o)
);

// File: tb/slot_access_ctrl_bench.sv
module slot_access_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        slot_tick = 1'b0;
    logic        pending = 1'b0;
    logic [1:0]  fb_i = '0;
    logic        tx_o;
    logic [3:0]  streak_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_tab [8];
    logic [15:0] m_lfsr;
    logic        m_act;
    logic [3:0]  m_streak;
    logic        m_en;

    always #5 clk = ~clk;

    slot_access_ctrl u_slot_access_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .slot_tick (slot_tick),
        .pending   (pending),
        .fb_i      (fb_i),
        .tx_o      (tx_o),
        .streak_o  (streak_o)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " tx"}, {15'd0, tx_o}, {15'd0, m_act});
        check({req, " streak"}, {12'd0, streak_o}, {12'd0, m_streak});
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!m_en) m_tab[a] = d;
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk);
        enable = v;
        @(negedge clk);
        m_en = v;
        m_act = 1'b0;
        if (!v) m_streak = '0;
    endtask

    task automatic slot(input logic pend, input logic [1:0] fb, input string req);
        logic [15:0] thr;
        @(negedge clk);
        pending = pend; fb_i = fb; slot_tick = 1'b1;
        if (m_en) begin
            thr = (fb == 2'd1) ? 16'd0 : m_tab[{m_act, fb}];
            if (m_act && fb == 2'd2) m_streak = (m_streak == 4'hF) ? 4'hF : m_streak + 1'b1;
            else                     m_streak = '0;
            m_act  = pend && (m_lfsr < thr);
            m_lfsr = lfsr_next(m_lfsr);
        end
        @(negedge clk);
        slot_tick = 1'b0;
        check_outs(req);
    endtask

    task automatic t_reset();
        check("R1 reset tx", {15'd0, tx_o}, 16'd0);
        check("R1 reset streak", {12'd0, streak_o}, 16'd0);
        set_enable(1'b1);
        for (int i = 0; i < 8; i++) slot(1'b1, i[1:0], "R1 zero thresholds");
        check_outs("R9 armed");
        set_enable(1'b0);
    endtask

    task automatic t_lock();
        set_enable(1'b1);
        cfg_write(3'd0, 16'hFFFF);   // ignored while enabled
        for (int i = 0; i < 4; i++) slot(1'b1, 2'd0, "R2 write ignored when enabled");
        set_enable(1'b0);
    endtask

    task automatic t_pair_select();
        cfg_write(3'd0, 16'hFFFF);   // waited, idle
        cfg_write(3'd4, 16'h0000);   // sent, idle
        cfg_write(3'd6, 16'hFFFF);   // sent, success
        cfg_write(3'd7, 16'h4000);   // sent, failure
        cfg_write(3'd3, 16'h8000);   // waited, failure
        set_enable(1'b1);
        for (int i = 0; i < 6; i++) begin
            slot(1'b1, 2'd0, "R3 pair select idle");
            slot(1'b1, 2'd3, "R3 pair select failure");
        end
        slot(1'b0, 2'd0, "R3 nothing pending");
    endtask

    task automatic t_streak();
        slot(1'b1, 2'd0, "R3 enter send");
        for (int i = 0; i < 20; i++) slot(1'b1, 2'd2, "R6 success run");
        check("R6 saturated", {12'd0, streak_o}, 16'h000F);
        slot(1'b1, 2'd3, "R6 clear on failure");
        check("R6 cleared", {12'd0, streak_o}, 16'd0);
    endtask

    task automatic t_busy();
        set_enable(1'b0);
        cfg_write(3'd1, 16'hFFFF);
        cfg_write(3'd5, 16'hFFFF);
        set_enable(1'b1);
        for (int i = 0; i < 4; i++) begin
            slot(1'b1, 2'd0, "R5 setup");
            slot(1'b1, 2'd1, "R5 busy forces wait");
            check("R5 wait after busy", {15'd0, tx_o}, 16'd0);
        end
    endtask

    task automatic t_hold_and_disable();
        slot(1'b1, 2'd0, "R8 setup");
        repeat (5) @(negedge clk);
        check_outs("R8 hold without strobe");
        set_enable(1'b0);
        check("R7 tx off", {15'd0, tx_o}, 16'd0);
        for (int i = 0; i < 3; i++) slot(1'b1, 2'd0, "R7 strobes ignored");
        set_enable(1'b1);
        for (int i = 0; i < 4; i++) slot(1'b1, 2'd0, "R4 sequence kept while off");
    endtask

    task automatic t_mix();
        set_enable(1'b0);
        for (int i = 0; i < 8; i++) cfg_write(i[2:0], 16'(i * 9000 + 1234));
        set_enable(1'b1);
        for (int i = 0; i < 200; i++) begin
            slot((i % 5) != 0, 2'((i * 7 + 3) % 4), "R4 mixed slots");
            if (i % 3 == 0) @(negedge clk);
        end
    endtask

    initial begin
        m_lfsr = 16'hACE1; m_act = 1'b0; m_streak = '0; m_en = 1'b0;
        for (int i = 0; i < 8; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_pair_select();
        t_streak();
        t_busy();
        t_hold_and_disable();
        t_mix();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule